// File: doc/BRIEF.md
# Banked Interrupt Priority Store

This block holds one 8-bit priority for each shared interrupt of an interrupt distributor. A register port reaches it in two ways. A byte access touches one interrupt. A 32-bit word access touches four consecutive interrupts, and its address must be 4-byte aligned. The byte address measured from the array base is the interrupt number. Interrupt numbers below the first shared interrupt (32), and numbers at or above the implemented count, have no storage. They read as zero and ignore writes.

Each request carries a secure attribute. A separate security-disable input controls how that attribute is used. When security is enabled and the request is non-secure, the access is restricted. It may only touch interrupts whose group bit (taken from the `irq_group` input) is 1, and it sees those priorities through a shifted view. Secure requests, and every request made while security is disabled, see the raw 8-bit value. Every request gets exactly one response one cycle later. A misaligned word access is the only request that gets an error.

Top module: `prio_bank`

## Requirements
- R1: After reset every stored priority is 0, so a secure byte read of any in-range interrupt returns 0.
- R2: A byte access to an interrupt number below 32, or at or above NUM_IRQ, returns read data 0, and its write changes no stored value.
- R3: A secure access, or any access while `sec_disable` is 1, reads the stored 8-bit value unchanged and writes the write byte unchanged.
- R4: A restricted access (non-secure, with `sec_disable` at 0) to an interrupt whose `irq_group` bit is 0 reads 0, and its write leaves the stored value untouched.
- R5: A restricted read of an interrupt whose group bit is 1 returns the stored value shifted left by one bit, truncated to 8 bits. So bit 0 of every byte lane of the result is 0.
- R6: A restricted write to an interrupt whose group bit is 1 stores 0x80 ORed with the write byte shifted right by one bit.
- R7: An aligned word read at address n returns interrupt n in bits [7:0], n+1 in [15:8], n+2 in [23:16] and n+3 in [31:24]. Each byte follows the rules of R2 to R5 on its own. A byte read returns its value in bits [7:0], and bits [31:8] are 0.
- R8: An aligned word write at address n does nothing at all if n is below 32 or n+3 is at or above NUM_IRQ. Otherwise byte lane k (bits [8k+7:8k]) is written to interrupt n+k under the per-byte rules of R3, R4 and R6.
- R9: A word access whose address bits [1:0] are not 00 returns `rsp_err` = 1 and read data 0, and changes no stored value. No other access sets `rsp_err`.
- R10: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` at 1, and 0 otherwise, including during reset. A write returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_disable | input | 1 | 1 = single security state; every access sees the raw values |
| irq_group | input | NUM_IRQ | Group bit per interrupt; 1 lets restricted accesses reach that interrupt |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit word access, 0 = byte access |
| req_secure | input | 1 | Secure attribute of the request |
| req_addr | input | ADDR_W | Byte offset from the array base (the interrupt number) |
| req_wdata | input | 32 | Write data; a byte write uses bits [7:0] |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Misaligned word access |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest case to reach is a word write whose four lanes get four different treatments. Some lanes are hidden by their group bit, some are rewritten through the forced-top-bit view, and the whole word must still be dropped when it touches the array edges. To reach it, the bench sets a group pattern with period 3, so every aligned word mixes permitted and hidden interrupts. It then issues restricted word writes over the full shared range, plus secure word writes at the first word below the range and the first word above it. After each phase the bench reads every byte back through the secure raw view. This shows through the ports which lanes changed and which did not.

// File: rtl/prio_pkg.sv
package prio_pkg;
   typedef logic [7:0] prio_t;

   localparam int LANES = 4;

   // view presented to a restricted reader: one bit up, top bit lost
   function automatic prio_t restricted_read_view(input prio_t stored);
      return {stored[6:0], 1'b0};
   endfunction

   // value stored by a restricted writer: top bit forced, one bit down
   function automatic prio_t restricted_write_view(input prio_t wval);
      return {1'b1, wval[7:1]};
   endfunction
endpackage

// File: rtl/prio_lane.sv
module prio_lane
   import prio_pkg::*;
(
   input  logic  in_range,
   input  logic  restricted,
   input  logic  grp,
   input  prio_t stored,
   input  prio_t wval,
   input  logic  wreq,
   output prio_t rval,
   output logic  wen,
   output prio_t wout
);
   logic visible;

   assign visible = in_range && (!restricted || grp);

   always_comb begin
      if (!visible)        rval = '0;
      else if (restricted) rval = restricted_read_view(stored);
      else                 rval = stored;
   end

   assign wen  = wreq && visible;
   assign wout = restricted ? restricted_write_view(wval) : wval;
endmodule

// File: rtl/prio_store.sv
module prio_store
   import prio_pkg::*;
#(
   parameter int ROWS  = 8,
   parameter int IDX_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             idx_ok,
   input  logic [LANES-1:0] we,
   input  prio_t            wbytes [LANES],
   output prio_t            rbytes [LANES]
);
   prio_t mem [ROWS][LANES];
   logic  hit;

   assign hit = idx_ok && (int'(idx) < ROWS);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign rbytes[k] = hit ? mem[idx][k] : '0;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r][k] <= '0;
         end else if (we[k] && hit) begin
            mem[idx][k] <= wbytes[k];
         end
      end
   end
endmodule

// File: rtl/prio_bank.sv
module prio_bank
   import prio_pkg::*;
#(
   parameter int NUM_IRQ      = 64,
   parameter int ADDR_W       = 10,
   parameter int FIRST_SHARED = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_disable,
   input  logic [NUM_IRQ-1:0] irq_group,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_word,
   input  logic               req_secure,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [31:0]        req_wdata,
   output logic               rsp_valid,
   output logic               rsp_err,
   output logic [31:0]        rsp_rdata
);
   localparam int ROW_W    = ADDR_W - 2;
   localparam int BASE_ROW = FIRST_SHARED / LANES;
   localparam int ROWS     = (NUM_IRQ - FIRST_SHARED) / LANES;
   localparam int IDX_W    = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int SPAN     = 2 ** ADDR_W;

   if (NUM_IRQ % 32 != 0 || NUM_IRQ <= FIRST_SHARED) begin : g_bad_count
      $error("prio_bank: NUM_IRQ must be a multiple of 32 above FIRST_SHARED");
   end
   if (NUM_IRQ > SPAN) begin : g_bad_addr
      $error("prio_bank: ADDR_W too narrow for NUM_IRQ");
   end
   if (FIRST_SHARED % LANES != 0) begin : g_bad_base
      $error("prio_bank: FIRST_SHARED must be word aligned");
   end

   logic [ROW_W-1:0] row;
   logic [1:0]       sel;
   logic             restricted;
   logic             misalign;
   logic             word_ok;
   logic [SPAN-1:0]  grp_pad;
   logic [IDX_W-1:0] sidx;
   logic [LANES-1:0] in_rng;
   logic [LANES-1:0] we;
   prio_t            stored [LANES];
   prio_t            rd_lane [LANES];
   prio_t            wb_lane [LANES];
   logic [31:0]      rd_word;

   assign row        = req_addr[ADDR_W-1:2];
   assign sel        = req_addr[1:0];
   assign restricted = !req_secure && !sec_disable;
   assign misalign   = req_word && (sel != 2'd0);
   assign word_ok    = &in_rng;
   assign grp_pad    = SPAN'(irq_group);
   assign sidx       = IDX_W'(row - ROW_W'(BASE_ROW));

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [ADDR_W-1:0] irq_k;
      logic              active_k;
      logic              wreq_k;
      prio_t             wval_k;

      assign irq_k     = {row, 2'(k)};
      assign in_rng[k] = ({1'b0, irq_k} >= (ADDR_W+1)'(FIRST_SHARED)) &&
                         ({1'b0, irq_k} <  (ADDR_W+1)'(NUM_IRQ));
      assign active_k  = req_word ? !misalign : (sel == 2'(k));
      assign wreq_k    = req_valid && req_write && active_k && (!req_word || word_ok);
      assign wval_k    = req_word ? req_wdata[8*k +: 8] : req_wdata[7:0];

      prio_lane u_lane (
         .in_range   (in_rng[k]),
         .restricted (restricted),
         .grp        (grp_pad[irq_k]),
         .stored     (stored[k]),
         .wval       (wval_k),
         .wreq       (wreq_k),
         .rval       (rd_lane[k]),
         .wen        (we[k]),
         .wout       (wb_lane[k])
      );
   end

   prio_store #(.ROWS(ROWS), .IDX_W(IDX_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx    (sidx),
      .idx_ok (in_rng[0]),
      .we     (we),
      .wbytes (wb_lane),
      .rbytes (stored)
   );

   always_comb begin
      if (req_word) rd_word = {rd_lane[3], rd_lane[2], rd_lane[1], rd_lane[0]};
      else          rd_word = {24'd0, rd_lane[sel]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && misalign;
         rsp_rdata <= (req_valid && !req_write && !misalign) ? rd_word : '0;
      end
   end
endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_disable,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_word,
   input logic              req_secure,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [31:0]       rsp_rdata
);
   logic bad_align;
   logic restr_rd;

   assign bad_align = req_word && (req_addr[1:0] != 2'd0);
   assign restr_rd  = req_valid && !req_write && !req_secure && !sec_disable;

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R10
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R10
   AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == '0)); // R10
   AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && bad_align) |=> (rsp_err && rsp_rdata == '0)); // R9
   AST_ERR_ONLY_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && bad_align) |=> !rsp_err); // R9
   AST_LOW_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr < ADDR_W'(32)) |=> (rsp_rdata == '0)); // R2
   AST_RESTRICTED_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restr_rd |=> (!rsp_rdata[0] && !rsp_rdata[8] && !rsp_rdata[16] && !rsp_rdata[24])); // R5
   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_word) |=> (rsp_rdata[31:8] == '0)); // R7
endmodule

bind prio_bank prio_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sec_disable (sec_disable),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_word    (req_word),
   .req_secure  (req_secure),
   .req_addr    (req_addr),
   .rsp_valid   (rsp_valid),
   .rsp_err     (rsp_err),
   .rsp_rdata   (rsp_rdata)
);

// File: tb/prio_bank_test.sv
module prio_bank_test;
   localparam int  PERIOD  = 10;
   localparam int  NIRQ    = 64;
   localparam int  AW      = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sec_disable = 1'b0;
   logic [NIRQ-1:0] irq_group = '0;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic            req_word = 1'b0;
   logic            req_secure = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [31:0]     req_wdata = '0;
   logic            rsp_valid;
   logic            rsp_err;
   logic [31:0]     rsp_rdata;

   int vectors = 0;
   int miscompares = 0;
   logic [7:0] mdl [0:127];

   always #(PERIOD/2) clk = ~clk;

   prio_bank #(.NUM_IRQ(NIRQ), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .irq_group(irq_group),
      .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
      .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   task automatic chk(input string tag, input logic [33:0] got, input logic [33:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int a, input bit sec);
      bit r;
      if (a < 32 || a >= NIRQ) return 8'h00;
      r = !sec && !sec_disable;
      if (r && !irq_group[a]) return 8'h00;
      return r ? {mdl[a][6:0], 1'b0} : mdl[a];
   endfunction

   function automatic void mdl_write(input int a, input logic [7:0] v, input bit sec);
      bit r;
      if (a < 32 || a >= NIRQ) return;
      r = !sec && !sec_disable;
      if (r && !irq_group[a]) return;
      mdl[a] = r ? {1'b1, v[7:1]} : v;
   endfunction

   task automatic acc(input string tag, input bit wr, input bit wd, input bit sec,
                      input int a, input logic [31:0] wv);
      logic [31:0] exp;
      bit eerr;
      eerr = wd && (a % 4 != 0);
      exp  = '0;
      if (!wr && !eerr)
         exp = wd ? {exp_byte(a+3, sec), exp_byte(a+2, sec), exp_byte(a+1, sec), exp_byte(a, sec)}
                  : {24'd0, exp_byte(a, sec)};
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_word = wd; req_secure = sec;
      req_addr = AW'(a); req_wdata = wv;
      @(negedge clk);
      req_valid = 1'b0;
      chk(tag, {rsp_valid, rsp_err, rsp_rdata}, {1'b1, eerr, exp});
      if (wr && !eerr) begin
         if (!wd) mdl_write(a, wv[7:0], sec);
         else if (a >= 32 && a + 3 < NIRQ)
            for (int i = 0; i < 4; i++) mdl_write(a + i, wv[8*i +: 8], sec);
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk("R10 reset", {33'd0, rsp_valid}, 34'd0);
      rst_n = 1'b1;

      // R1 / R2: reset contents and unbacked numbers, raw view
      for (int a = 0; a < 72; a++) acc("R1", 0, 0, 1, a, 0);

      for (int i = 0; i < NIRQ; i++) irq_group[i] = ((i * 7) % 3) != 0;

      // R3 / R2: secure raw writes over the whole span, read back raw
      for (int a = 0; a < 72; a++) acc("R3", 1, 0, 1, a, 32'((a * 37 + 11) & 255));
      for (int a = 0; a < 72; a++) acc("R2", 0, 0, 1, a, 0);

      // R4 / R5: restricted reads of mixed groups
      for (int a = 0; a < 72; a++) acc("R5", 0, 0, 0, a, 0);

      // R6 / R4: restricted writes, then raw readback
      for (int a = 0; a < 72; a++) acc("R6", 1, 0, 0, a, 32'((a * 91 + 5) & 255));
      for (int a = 0; a < 72; a++) acc("R4", 0, 0, 1, a, 0);

      // R3: security disabled, non-secure sees raw
      sec_disable = 1'b1;
      for (int a = 40; a < 48; a++) acc("R3 dis", 1, 0, 0, a, 32'(a ^ 8'h5a));
      for (int a = 32; a < 72; a++) acc("R3 dis", 0, 0, 0, a, 0);
      sec_disable = 1'b0;

      // R7: word packing, both views
      for (int a = 0; a < 72; a += 4) acc("R7", 0, 1, 1, a, 0);
      for (int a = 0; a < 72; a += 4) acc("R7", 0, 1, 0, a, 0);

      // R8: edge words dropped, inner words per byte
      acc("R8 low", 1, 1, 1, 28, 32'hA1B2C3D4);
      acc("R8 high", 1, 1, 1, 64, 32'h11223344);
      for (int a = 32; a < 64; a += 4) acc("R8", 1, 1, 1, a, 32'(a * 32'h01030507));
      for (int a = 0; a < 72; a++) acc("R8", 0, 0, 1, a, 0);
      for (int a = 32; a < 64; a += 4) acc("R8 ns", 1, 1, 0, a, 32'(a * 32'h0B0D1113) ^ 32'hF0F0F0F0);
      for (int a = 28; a < 72; a += 4) acc("R8 ns", 0, 1, 1, a, 0);

      // R9: misaligned words
      for (int a = 33; a < 36; a++) acc("R9", 1, 1, 1, a, 32'hFFFFFFFF);
      for (int a = 33; a < 36; a++) acc("R9", 0, 1, 1, a, 0);
      for (int a = 32; a < 40; a++) acc("R9", 0, 0, 1, a, 0);

      // R10: strobe drops when idle
      acc("R10", 0, 0, 1, 40, 0);
      @(negedge clk);
      chk("R10 idle", {33'd0, rsp_valid}, 34'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule